// File: doc/BRIEF.md
# Dual Programmable Parallel Port Group

This block provides 48 general-purpose I/O lines arranged as two identical groups. Each group holds three 8-bit ports, named A, B and C, together with one direction control register. A host reaches all of them through a byte-wide synchronous read/write bus that addresses a 16-byte window. Each group takes four consecutive offsets. The upper half of the window is not mapped.

Each group's direction is set by writing a mode word to that group's control register. Ports A and B change direction as whole bytes. Port C changes direction one nibble at a time. Each line has its own output latch, and the latched value is always present on the pin output. A separate output enable per line decides whether the pin is actually driven.

A read of a port returns two kinds of value in one byte: the live pin level on every input line, and the latched value on every output line. Only the plain static input/output mode is supported.

Top module: `pport_dual`

## Requirements
- R1: After a synchronous reset, every `pin_oe` bit is 0, every `pin_out` bit is 0, `rdata` is 0x00, and both control registers read back 0x9B.
- R2: Group g (0 or 1) places port A at offset 4g, port B at 4g+1, port C at 4g+2 and its control register at 4g+3. Port A of group g maps to pin bits [24g+7:24g], port B to [24g+15:24g+8], and port C to [24g+23:24g+16].
- R3: A control write with bit 7 set is a mode word. In a mode word, bit 4 = 1 makes port A an input and bit 4 = 0 makes it an output. Bit 1 controls port B in the same way.
- R4: In a mode word, bit 3 sets the direction of port C bits 7..4 and bit 0 sets the direction of port C bits 3..0. A value of 1 means input and 0 means output.
- R5: The mode word 0x80 makes every line of its own group an output and leaves the other group unchanged.
- R6: A control write with bit 7 clear changes neither the direction state nor the control readback.
- R7: A write to a port offset loads that port's latch. From the next cycle, `pin_out` carries the latch and `pin_oe` is 1 exactly on the output-configured lines.
- R8: A read is issued by asserting `rd_en` for one cycle, and the result appears on `rdata` in the following cycle. A port read returns `pin_in` on input lines and the latch on output lines.
- R9: A latch keeps its value across direction changes, so a line that is switched to output drives the value written before the switch.
- R10: A read of a control offset returns the last mode word written to it.
- R11: Offsets 8 to 15 read as 0x00, and writes to them change no pin and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| rd_en | input | 1 | Read strobe; `rdata` is updated on the next cycle |
| addr | input | 4 | Byte offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Live pin levels |
| pin_out | output | 48 | Output latch values |
| pin_oe | output | 48 | Per-line output enable |

## Verification
The main function is exercised with a series of mode words. One makes every line an input, one (0x80) makes every line an output, and others make a single port or a single port C nibble the only input. Comparing these cases separates the control bit of port A from that of port B, and the bit of each C nibble from the other. Reads are made while `pin_in` holds a pattern different from the latches, so each returned bit shows whether it came from the pin or from the latch. Non-mode control writes and accesses to unmapped offsets are each followed by a readback and a pin check to confirm that they had no effect.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int MODE_FLAG = 7;
  localparam int A_IN_BIT  = 4;
  localparam int B_IN_BIT  = 1;
  localparam int CHI_IN_BIT = 3;
  localparam int CLO_IN_BIT = 0;
  localparam logic [7:0] MODE_ALL_IN = 8'h9B;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pport_dir.sv
module pport_dir
  import pport_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic [7:0]          mode,
  output logic [3*PORT_W-1:0] oe
);
  localparam int HALF = PORT_W / 2;

  always_comb begin
    oe[0*PORT_W +: PORT_W]      = {PORT_W{~mode[A_IN_BIT]}};
    oe[1*PORT_W +: PORT_W]      = {PORT_W{~mode[B_IN_BIT]}};
    oe[2*PORT_W +: HALF]        = {HALF{~mode[CLO_IN_BIT]}};
    oe[2*PORT_W + HALF +: HALF] = {HALF{~mode[CHI_IN_BIT]}};
  end
endmodule

// File: rtl/pport_group.sv
module pport_group
  import pport_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  reg_sel_e            sel,
  input  logic [7:0]          wdata,
  input  logic [3*PORT_W-1:0] pin_in,
  output logic [3*PORT_W-1:0] pin_out,
  output logic [3*PORT_W-1:0] pin_oe,
  output logic [7:0]          rd_val
);
  localparam int GRP_W = 3 * PORT_W;
  localparam int HALF  = PORT_W / 2;

  logic [2:0][PORT_W-1:0] lat_q;
  logic [7:0]             ctrl_q;
  logic [GRP_W-1:0]       oe_q;
  logic [GRP_W-1:0]       oe_next;
  logic [1:0]             idx;

  assign idx = sel;

  pport_dir #(.PORT_W(PORT_W)) u_dir (
    .mode (wdata),
    .oe   (oe_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= '0;
      ctrl_q <= MODE_ALL_IN;
      oe_q   <= '0;
    end else if (wr_en) begin
      if (sel == SEL_CTRL) begin
        if (wdata[MODE_FLAG]) begin
          ctrl_q <= wdata;
          oe_q   <= oe_next;
        end
      end else begin
        lat_q[idx] <= wdata[PORT_W-1:0];
      end
    end
  end

  assign pin_out = lat_q;
  assign pin_oe  = oe_q;

  always_comb begin
    rd_val = '0;
    if (sel == SEL_CTRL) begin
      rd_val = ctrl_q;
    end else begin
      rd_val[PORT_W-1:0] = (pin_in[idx*PORT_W +: PORT_W] & ~oe_q[idx*PORT_W +: PORT_W])
                         | (lat_q[idx] & oe_q[idx*PORT_W +: PORT_W]);
    end
  end

  assert_mode_ab_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_CTRL && wdata[MODE_FLAG]) |=>
      (pin_oe[0 +: PORT_W] == {PORT_W{~$past(wdata[A_IN_BIT])}}) &&
      (pin_oe[PORT_W +: PORT_W] == {PORT_W{~$past(wdata[B_IN_BIT])}}));

  assert_mode_cnib_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_CTRL && wdata[MODE_FLAG]) |=>
      (pin_oe[2*PORT_W +: HALF] == {HALF{~$past(wdata[CLO_IN_BIT])}}) &&
      (pin_oe[2*PORT_W + HALF +: HALF] == {HALF{~$past(wdata[CHI_IN_BIT])}}));

  assert_no_mode_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_CTRL && !wdata[MODE_FLAG]) |=> $stable(pin_oe));

  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel != SEL_CTRL) |=> $stable(pin_out));
endmodule

// File: rtl/pport_dual.sv
module pport_dual
  import pport_pkg::*;
#(
  parameter int NGROUPS = 2,
  parameter int PORT_W  = 8,
  parameter int ADDR_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [7:0]                      wdata,
  output logic [7:0]                      rdata,
  input  logic [NGROUPS*3*PORT_W-1:0]     pin_in,
  output logic [NGROUPS*3*PORT_W-1:0]     pin_out,
  output logic [NGROUPS*3*PORT_W-1:0]     pin_oe
);
  localparam int GRP_W  = 3 * PORT_W;
  localparam int SPAN   = NGROUPS * 4;
  localparam int GIDX_W = ADDR_W - 2;

  logic [GIDX_W-1:0]        grp_idx;
  logic                     in_range;
  reg_sel_e                 sel;
  logic [NGROUPS-1:0]       grp_we;
  logic [NGROUPS-1:0][7:0]  rd_vals;
  logic [7:0]               rd_mux;

  assign grp_idx  = addr[ADDR_W-1:2];
  assign in_range = {1'b0, addr} < (ADDR_W+1)'(SPAN);
  assign sel      = reg_sel_e'(addr[1:0]);

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    assign grp_we[g] = wr_en && in_range && (grp_idx == GIDX_W'(g));

    pport_group #(.PORT_W(PORT_W)) u_group (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (grp_we[g]),
      .sel     (sel),
      .wdata   (wdata),
      .pin_in  (pin_in[g*GRP_W +: GRP_W]),
      .pin_out (pin_out[g*GRP_W +: GRP_W]),
      .pin_oe  (pin_oe[g*GRP_W +: GRP_W]),
      .rd_val  (rd_vals[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NGROUPS; i++) begin
      if (in_range && grp_idx == GIDX_W'(i)) rd_mux = rd_vals[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assert_one_group_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grp_we));

  assert_unmapped_read_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !in_range) |=> (rdata == 8'h00));

  assert_unmapped_write_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !in_range) |=> ($stable(pin_oe) && $stable(pin_out)));

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/pport_dual_tb.sv
module pport_dual_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 48;

  logic          clk = 0;
  logic          rst = 1;
  logic          wr_en = 0, rd_en = 0;
  logic [3:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;

  int n_checks = 0;
  int n_fail = 0;
  logic rd_d = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  logic [7:0] m_ctrl [2];
  logic [7:0] m_lat  [6];

  always #(CLK_PERIOD/2) clk = ~clk;

  pport_dual u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  function automatic logic [23:0] grp_oe(logic [7:0] m);
    logic [23:0] v;
    v[7:0]   = m[4] ? 8'h00 : 8'hFF;
    v[15:8]  = m[1] ? 8'h00 : 8'hFF;
    v[19:16] = m[0] ? 4'h0 : 4'hF;
    v[23:20] = m[3] ? 4'h0 : 4'hF;
    return v;
  endfunction

  function automatic logic [NP-1:0] model_oe();
    return {grp_oe(m_ctrl[1]), grp_oe(m_ctrl[0])};
  endfunction

  function automatic logic [NP-1:0] model_out();
    return {m_lat[5], m_lat[4], m_lat[3], m_lat[2], m_lat[1], m_lat[0]};
  endfunction

  function automatic logic [7:0] model_read(int a);
    logic [NP-1:0] oe;
    int g, p;
    if (a >= 8) return 8'h00;
    g = a / 4; p = a % 4;
    if (p == 3) return m_ctrl[g];
    oe = model_oe();
    return (pin_in[g*24+p*8 +: 8] & ~oe[g*24+p*8 +: 8]) |
           (m_lat[g*3+p] & oe[g*24+p*8 +: 8]);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = 4'(a); wdata = d;
    @(posedge clk);
    if (a < 8) begin
      if (a % 4 == 3) begin
        if (d[7]) m_ctrl[a/4] = d;
      end else begin
        m_lat[(a/4)*3 + a%4] = d;
      end
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int a, string tag);
    @(negedge clk);
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    rd_en = 1; addr = 4'(a);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic check_pins(string tag);
    @(negedge clk);
    check({tag, " oe"}, 64'(pin_oe), 64'(model_oe()));
    check({tag, " out"}, 64'(pin_out), 64'(model_out()));
  endtask

  always @(posedge clk) rd_d <= rd_en;

  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 0, 1);
      end else begin
        check(tag_q.pop_front(), 64'(rdata), 64'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    m_ctrl[0] = 8'h9B; m_ctrl[1] = 8'h9B;
    for (int i = 0; i < 6; i++) m_lat[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    check("R1 rdata after reset", 64'(rdata), 64'h00);
    check_pins("R1 reset pins");
    rd(3, "R1 R10 ctrl0 reset readback");
    rd(7, "R1 R10 ctrl1 reset readback");

    // latches load while inputs
    for (int a = 0; a < 7; a++) if (a != 3) wr(a, 8'h11 * 8'(a + 1) ^ 8'h5A);
    check_pins("R7 latches with all inputs");
    pin_in = 48'hC3A5_5AF0_0F96;
    for (int a = 0; a < 7; a++) if (a != 3) rd(a, "R8 R2 input read pattern1");

    // group 0 all outputs
    wr(3, 8'h80);
    check_pins("R5 R9 group0 all out");
    rd(3, "R10 ctrl0 after 0x80");
    rd(7, "R5 ctrl1 unchanged");
    for (int a = 0; a < 7; a++) if (a != 3) rd(a, "R8 R9 mixed group read");

    // port-wise mode words on group 1
    wr(7, 8'h90);
    check_pins("R3 port A input only");
    wr(7, 8'h82);
    check_pins("R3 port B input only");
    rd(4, "R3 R8 portA out read");
    rd(5, "R3 R8 portB in read");
    wr(3, 8'h88);
    check_pins("R4 C upper nibble input");
    rd(2, "R4 R8 port C split nibble");
    wr(3, 8'h81);
    check_pins("R4 C lower nibble input");
    pin_in = 48'h3C5A_A50F_F069;
    rd(2, "R4 R8 port C lower in pattern2");
    rd(6, "R8 port C group1 pattern2");

    // non-mode write ignored
    wr(3, 8'h1B);
    check_pins("R6 non-mode write pins");
    rd(3, "R6 non-mode write readback");

    // unmapped offsets
    for (int a = 8; a < 16; a++) wr(a, 8'hFF);
    check_pins("R11 unmapped writes");
    rd(9, "R11 unmapped read 9");
    rd(15, "R11 unmapped read 15");
    rd(11, "R11 unmapped read 11");

    // latch update while output, then retention across switch
    wr(1, 8'hE7);
    check_pins("R7 write to output port");
    wr(7, 8'h9B);
    wr(4, 8'h3D);
    check_pins("R9 write while input");
    wr(7, 8'h80);
    check_pins("R9 switch to output drives latch");
    rd(4, "R9 R8 readback latched value");
    rd(7, "R10 ctrl1 last mode word");

    repeat (3) @(negedge clk);
    check("scoreboard drained", 64'(exp_q.size()), 64'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule